// File: doc/BRIEF.md
# Absolute encoder request frame transmitter

This block builds the request frames that a servo drive sends to an absolute position encoder over a half-duplex RS485 link. A single-cycle request strobe carries a 4-bit request code and, for memory-access requests, an address byte and a data byte. The block then raises the transceiver enable and waits a programmable settle time. It shifts the frame out on the transmit-data line, releases the line for the encoder's reply and pulses a done flag.

Every field on the wire is ten bit times long: a low start bit, eight payload bits sent least significant bit first, and a high stop bit. The first field is always the control field. Its payload holds a fixed 3-bit synchronisation pattern, the request code and an even parity bit. A memory write appends address, data and checksum fields. A memory read appends address and checksum fields. All other codes send the control field alone. The bit period is set by a divider terminal-count input, and a terminal count of 39 gives 2.5 Mbit/s from a 100 MHz clock.

Top module: `enc_req_tx`

## Requirements
- R1: After reset and whenever no request is in progress, `txd_o` is 1 and `txen_o`, `busy_o` and `done_o` are 0.
- R2: One bit time lasts `div_tc_i + 1` clock cycles, so the default terminal count of 39 gives 40 cycles per bit.
- R3: Every field is a 0 start bit, then 8 payload bits LSB first, then a 1 stop bit.
- R4: The control-field payload is `{^id, id[3:0], 3'b010}`. Bits 0..2 carry the sync pattern 0,1,0, bits 3..6 carry the code LSB first, and bit 7 is the XOR of the four code bits (even parity).
- R5: Code 6 (memory write) sends, in order, the control field, an address field (`addr_i`), a data field (`data_i`) and a checksum field.
- R6: Code 0xD (memory read) sends, in order, the control field, an address field (`addr_i`) and a checksum field.
- R7: Every code other than 6 and 0xD sends the control field only.
- R8: The checksum is the remainder of division by x^8 + 1 over the payload bits of the preceding fields in send order, sent so that its payload value equals the XOR of those payload bytes.
- R9: `txen_o` rises in the cycle after a request is accepted. `txd_o` stays 1 for `max(settle_i,1)` bit times before the first start bit begins.
- R10: `txen_o` falls exactly when the final stop bit's time ends. In that same cycle `done_o` is 1 for one cycle. `busy_o` is 1 from the cycle after acceptance through the done cycle and 0 in the cycle after.
- R11: A request strobe while `busy_o` is 1 is ignored: the frame in progress is unchanged, and no further frame or done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| req_i | input | 1 | Request strobe, accepted when idle |
| id_i | input | 4 | Request code |
| addr_i | input | 8 | Memory address for codes 6 and 0xD |
| data_i | input | 8 | Memory data for code 6 |
| div_tc_i | input | 8 | Bit divider terminal count (bit = value + 1 cycles) |
| settle_i | input | 4 | Settle delay in bit times; 0 acts as 1 |
| txd_o | output | 1 | Serial transmit data toward the transceiver |
| txen_o | output | 1 | Transceiver driver enable |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse when the line is released |

## Verification
A wrong field counter or a wrong code decode shows up as a field too many or too few. It can be seen at the first stop bit, where a control-only frame must drop `txen_o` and pulse `done_o`. A corrupted shifter or checksum register only shows in the sampled payload bits of the affected field, within one field time (ten bits). A bit timer that miscounts moves the first start-bit edge relative to the rise of `txen_o`. The bench therefore checks the last settle cycle and the first start cycle exactly, and samples every later bit mid-period.

// File: rtl/enc_req_pkg.sv
package enc_req_pkg;
  typedef enum logic [1:0] {
    FK_CTRL = 2'd0,
    FK_ADDR = 2'd1,
    FK_DATA = 2'd2,
    FK_CSUM = 2'd3
  } fld_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SEND   = 2'd2,
    ST_DONE   = 2'd3
  } tx_state_t;

  localparam logic [3:0] CODE_MEM_WR = 4'h6;
  localparam logic [3:0] CODE_MEM_RD = 4'hD;
  localparam logic [2:0] SYNC_PAT    = 3'b010;
  localparam int unsigned FIELD_BITS = 10;
  localparam int unsigned LAST_BIT   = FIELD_BITS - 1;

  function automatic logic [7:0] ctrl_payload(input logic [3:0] code);
    ctrl_payload = {^code, code, SYNC_PAT};
  endfunction
endpackage

// File: rtl/enc_bit_tick.sv
module enc_bit_tick #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] tc_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clear_i | run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)            cnt_d = '0;
    else if (cnt_q >= tc_i) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick_o = run_i & ~clear_i & (cnt_q == tc_i);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && tc_i != '0 && $stable(tc_i)) |=> !tick_o);
endmodule

// File: rtl/enc_req_plan.sv
module enc_req_plan
  import enc_req_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic [1:0] idx_i,
  output fld_kind_t  kind_o,
  output logic [1:0] last_o
);
  always_comb begin
    kind_o = FK_CTRL;
    last_o = 2'd0;
    if (code_i == CODE_MEM_WR) begin
      last_o = 2'd3;
      case (idx_i)
        2'd0:    kind_o = FK_CTRL;
        2'd1:    kind_o = FK_ADDR;
        2'd2:    kind_o = FK_DATA;
        default: kind_o = FK_CSUM;
      endcase
    end else if (code_i == CODE_MEM_RD) begin
      last_o = 2'd2;
      case (idx_i)
        2'd0:    kind_o = FK_CTRL;
        2'd1:    kind_o = FK_ADDR;
        default: kind_o = FK_CSUM;
      endcase
    end else begin
      kind_o = (idx_i == 2'd0) ? FK_CTRL : FK_CSUM;
    end
  end
endmodule

// File: rtl/enc_req_crc.sv
module enc_req_crc #(
  parameter int unsigned CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;
  logic             crc_en;

  assign fb     = bit_i ^ crc_q[CRC_W-1];
  assign crc_en = clear_i | shift_i;

  always_comb begin
    if (clear_i) crc_d = '0;
    else         crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R8
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (crc_o == '0));
endmodule

// File: rtl/enc_req_tx.sv
module enc_req_tx
  import enc_req_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned SETTLE_W = 4,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [3:0]          id_i,
  input  logic [BYTE_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic [DIV_W-1:0]    div_tc_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                txd_o,
  output logic                txen_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned BIT_IDX_W = $clog2(FIELD_BITS);

  tx_state_t             state_q, state_d;
  logic [3:0]            code_q;
  logic [BYTE_W-1:0]     addr_q, data_q;
  logic [SETTLE_W-1:0]   settle_q, settle_d;
  logic [SETTLE_W-1:0]   scnt_q, scnt_d;
  logic [1:0]            fld_q, fld_d;
  logic [BIT_IDX_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0]     sh_q, sh_d;

  logic                  accept;
  logic                  tick;
  logic                  timer_run;
  logic                  in_payload;
  logic                  crc_shift;
  logic [BYTE_W-1:0]     crc_val, crc_rev;
  logic [BYTE_W-1:0]     next_payload;
  fld_kind_t             cur_kind, nxt_kind;
  logic [1:0]            last_fld, last_unused;
  logic                  hold_en, seq_en;

  assign accept     = (state_q == ST_IDLE) & req_i;
  assign timer_run  = (state_q == ST_SETTLE) | (state_q == ST_SEND);
  assign in_payload = (bit_q != '0) & (bit_q != BIT_IDX_W'(LAST_BIT));
  assign crc_shift  = tick & (state_q == ST_SEND) & in_payload & (cur_kind != FK_CSUM);
  assign settle_d   = (settle_i == '0) ? SETTLE_W'(1) : settle_i;

  enc_bit_tick #(.CNT_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .run_i   (timer_run),
    .tc_i    (div_tc_i),
    .tick_o  (tick)
  );

  enc_req_plan u_plan_cur (
    .code_i (code_q),
    .idx_i  (fld_q),
    .kind_o (cur_kind),
    .last_o (last_fld)
  );

  enc_req_plan u_plan_nxt (
    .code_i (code_q),
    .idx_i  (fld_q + 2'd1),
    .kind_o (nxt_kind),
    .last_o (last_unused)
  );

  enc_req_crc #(.CRC_W(BYTE_W)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .shift_i (crc_shift),
    .bit_i   (sh_q[0]),
    .crc_o   (crc_val)
  );

  // The checksum register holds the first-sent bit in its MSB.
  for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
    assign crc_rev[g] = crc_val[BYTE_W-1-g];
  end

  always_comb begin
    case (nxt_kind)
      FK_ADDR: next_payload = addr_q;
      FK_DATA: next_payload = data_q;
      FK_CSUM: next_payload = crc_rev;
      default: next_payload = ctrl_payload(code_q);
    endcase
  end

  always_comb begin
    state_d = state_q;
    scnt_d  = scnt_q;
    fld_d   = fld_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_SETTLE;
          scnt_d  = '0;
        end
      end
      ST_SETTLE: begin
        if (tick) begin
          if (scnt_q == settle_q - 1'b1) begin
            state_d = ST_SEND;
            fld_d   = 2'd0;
            bit_d   = '0;
            sh_d    = ctrl_payload(code_q);
          end else begin
            scnt_d = scnt_q + 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (bit_q == BIT_IDX_W'(LAST_BIT)) begin
            if (fld_q == last_fld) begin
              state_d = ST_DONE;
            end else begin
              fld_d = fld_q + 2'd1;
              bit_d = '0;
              sh_d  = next_payload;
            end
          end else begin
            bit_d = bit_q + 1'b1;
            if (in_payload) sh_d = {1'b0, sh_q[BYTE_W-1:1]};
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign hold_en = accept;
  assign seq_en  = tick | accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      settle_q <= SETTLE_W'(1);
    end else if (hold_en) begin
      code_q   <= id_i;
      addr_q   <= addr_i;
      data_q   <= data_i;
      settle_q <= settle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      fld_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (seq_en) begin
      scnt_q <= scnt_d;
      fld_q  <= fld_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  always_comb begin
    txd_o = 1'b1;
    if (state_q == ST_SEND) begin
      if (bit_q == '0)          txd_o = 1'b0;
      else if (in_payload)      txd_o = sh_q[0];
      else                      txd_o = 1'b1;
    end
  end

  assign txen_o = timer_run;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (txd_o && !txen_o && !done_o));
  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!txen_o && busy_o));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R9
  enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen_o) |-> txd_o);
  // R11
  req_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> (busy_o && $stable(code_q) && $stable(addr_q)));
endmodule

// File: tb/test_enc_req_tx.sv
module test_enc_req_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       req_i;
  logic [3:0] id_i;
  logic [7:0] addr_i, data_i, div_tc_i;
  logic [3:0] settle_i;
  logic       txd_o, txen_o, busy_o, done_o;

  int checks;
  int fails;
  int done_cnt;
  int cur;

  enc_req_tx i_enc_req_tx (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .id_i(id_i),
    .addr_i(addr_i), .data_i(data_i), .div_tc_i(div_tc_i),
    .settle_i(settle_i), .txd_o(txd_o), .txen_o(txen_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (done_o) done_cnt <= done_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic goto_edge(input int off);
    repeat (off - cur) @(posedge clk);
    @(negedge clk);
    cur = off;
  endtask

  task automatic run_frame(input logic [3:0] code, input logic [7:0] adr,
                           input logic [7:0] dat, input int settle,
                           input int tc, input bit poke, input string len_tag);
    int L, S, nf, d0;
    logic [7:0] exp_f [4];
    logic [9:0] cap;
    string ftag;
    L = tc + 1;
    S = (settle == 0) ? 1 : settle;
    exp_f[0] = {^code, code, 3'b010};
    if (code == 4'h6) begin
      nf = 4; exp_f[1] = adr; exp_f[2] = dat;
      exp_f[3] = exp_f[0] ^ adr ^ dat;
    end else if (code == 4'hD) begin
      nf = 3; exp_f[1] = adr; exp_f[2] = exp_f[0] ^ adr; exp_f[3] = 8'h00;
    end else begin
      nf = 1; exp_f[1] = 8'h00; exp_f[2] = 8'h00; exp_f[3] = 8'h00;
    end
    div_tc_i = 8'(tc); settle_i = 4'(settle);
    id_i = code; addr_i = adr; data_i = dat; req_i = 1'b1;
    d0 = done_cnt;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    cur = 0;
    // R9: enable raised right after acceptance, line still high
    check(txen_o && busy_o && txd_o, "R9 enable at accept", {txen_o, busy_o, txd_o}, 3'b111);
    goto_edge(L*S - 1);
    check(txd_o == 1'b1, "R9 settle high", txd_o, 1);
    goto_edge(L*S);
    // R2: start bit begins exactly after the settle bit times
    check(txd_o == 1'b0, "R2 start edge timing", txd_o, 0);
    for (int f = 0; f < nf; f++) begin
      for (int k = 0; k < 10; k++) begin
        goto_edge(L*(S + 10*f + k) + L/2);
        cap[k] = txd_o;
        if (poke && f == 0 && k == 3) begin
          req_i = 1'b1; id_i = 4'h0; addr_i = 8'hFF; data_i = 8'hFF;
          @(posedge clk);
          @(negedge clk);
          req_i = 1'b0;
          cur = cur + 1;
        end
      end
      check(cap[0] == 1'b0 && cap[9] == 1'b1, "R3 start/stop bits", {cap[9], cap[0]}, 2'b10);
      if (f == 0)           ftag = poke ? "R11 control field kept" : "R4 control field";
      else if (f == nf - 1) ftag = "R8 checksum field";
      else                  ftag = (code == 4'h6) ? "R5 write payload" : "R6 read payload";
      check(cap[8:1] == exp_f[f], ftag, cap[8:1], exp_f[f]);
    end
    goto_edge(L*(S + 10*nf) - 1);
    check(txen_o && !done_o, "R10 enable held through stop", {txen_o, done_o}, 2'b10);
    goto_edge(L*(S + 10*nf));
    check(done_o && !txen_o && busy_o, {len_tag, " R10 release and done"},
          {done_o, txen_o, busy_o}, 3'b101);
    goto_edge(L*(S + 10*nf) + 1);
    check(!done_o && !busy_o && txd_o && !txen_o, "R1 idle after frame",
          {done_o, busy_o, txd_o, txen_o}, 4'b0010);
    repeat (3*L) @(negedge clk);
    check(done_cnt == d0 + 1 && !txen_o, poke ? "R11 no extra frame" : "R10 single done",
          done_cnt - d0, 1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; done_cnt = 0; cur = 0;
    rst_n = 1'b0; req_i = 1'b0; id_i = '0; addr_i = '0; data_i = '0;
    div_tc_i = 8'd39; settle_i = 4'd1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txd_o && !txen_o && !busy_o && !done_o, "R1 reset state",
          {txd_o, txen_o, busy_o, done_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(4'h0, 8'h00, 8'h00, 1, 39, 1'b0, "R7");
    run_frame(4'h7, 8'h12, 8'h34, 2, 39, 1'b0, "R7");
    run_frame(4'h6, 8'hA5, 8'h3C, 1, 39, 1'b0, "R5");
    run_frame(4'hD, 8'h5A, 8'h00, 3, 39, 1'b0, "R6");
    run_frame(4'hC, 8'h00, 8'h00, 0, 9, 1'b0, "R7");
    run_frame(4'h6, 8'h7F, 8'h81, 0, 9, 1'b0, "R5");
    run_frame(4'h3, 8'h00, 8'h00, 1, 39, 1'b1, "R7");
    run_frame(4'h8, 8'h00, 8'h00, 1, 39, 1'b0, "R7");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule